// File: doc/BRIEF.md
# V.110 Status-Bit Change Reporter

This block sits on the receive side of a channel running the V.110/X.30 rate-adaption frame. It takes a byte stream that is already aligned to 10-octet frames, with a start strobe on the first octet. From every complete frame it collects the seven E bits, the six S bits and the two X bits into one 15-bit status word. At the end of the frame it compares that word with a reference word, which holds the last value it reported. If any bit differs, it sends a single report that carries the whole word, and it copies the word into the reference.

Each frame yields at most one report, however many status bits changed in it. A host receive-abort command changes this: the next frame that completes reports an all-zero word, whatever it carried. That report also clears the reference. Octet 0 of each frame is the all-zero sync pattern and is not inspected. The block does no synchronisation search, no rate adaption and no HDLC processing.

The input side is a valid/ready stream. The block never applies back-pressure: `oct_ready` is held high, and an octet counts as transferred in every cycle with `oct_valid` high. Idle cycles may fall between octets. The report side is a plain one-cycle strobe with a data word, because the block has nothing to buffer it in.

Top module: `v110_chg_det`

## Requirements
- R1: `oct_ready` is 1 in every cycle after reset. An octet is consumed only in a cycle where `oct_valid` is 1, and cycles with `oct_valid` at 0 leave the frame position unchanged.
- R2: An octet accepted with `oct_sof` = 1 is octet 0, and the octets accepted after it are octets 1 to 9. A new `oct_sof` abandons a partial frame. Octets accepted before the first `oct_sof`, or after octet 9 and before the next `oct_sof`, are ignored.
- R3: Status word layout. Bits [14:8] are E1..E7, taken from bits [6:0] of octet 5 (E1 = data bit 6). Bits [7:2] are S bits: bit 2+j is data bit 0 of octet 1, 3, 4, 6, 8, 9 for j = 0..5 in that order. Bit 0 is data bit 0 of octet 2, and bit 1 is data bit 0 of octet 7.
- R4: When a completed frame's status word differs from the reference, `chg_valid` is high for exactly one cycle, namely the cycle after octet 9 is accepted, and `chg_status` carries that word.
- R5: A frame in which several status bits changed produces only one report, and that report carries all the new values.
- R6: A frame whose status word equals the reference produces no report. Each report loads its word into the reference.
- R7: An `abort_req` pulse at any time, including between frames, causes the next completed frame to be reported with `chg_status` = 0. This report is issued even if nothing changed. It sets the reference to 0, and it is issued only once.
- R8: After reset the reference is 0 and `chg_valid` is 0, so a first frame with all status bits 0 produces no report.
- R9: The leading bit (bit 7) of octets 1 to 9 and the data bits outside the R3 positions have no effect on the reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oct_valid | input | 1 | Octet present on `oct_data` |
| oct_ready | output | 1 | Always 1; the block never stalls the stream |
| oct_data | input | 8 | Received octet, bit 7 transmitted first |
| oct_sof | input | 1 | Marks octet 0 of a frame, qualified by `oct_valid` |
| abort_req | input | 1 | One-cycle host receive-abort command |
| chg_valid | output | 1 | One-cycle report strobe |
| chg_status | output | 15 | Reported E/S/X word, layout as in R3 |

## Verification
The main test is a walk of a single set bit across all 15 status positions, one frame per position. This catches any swapped or misplaced bit in the mapping. Around the walk run several other patterns:
- repeated identical frames, which must stay silent;
- a frame in which E, S and X change together, which must give one merged report;
- frames with idle gaps and with changing filler and leading bits;
- stray octets before the first start strobe and after a frame ends, and a truncated frame restarted by a new start strobe.

Aborts are applied in three ways: in the middle of a changed frame, in a frame with no change, and between frames. Each case shows whether the zero report and the reference clear really happen.

// File: rtl/v110_pkg.sv
package v110_pkg;
  localparam int FRAME_OCTETS = 10;
  localparam int E_OCTET      = 5;
  localparam int E_BITS       = 7;
  localparam int S_BITS       = 6;
  localparam int X_BITS       = 2;
  localparam int STAT_W       = E_BITS + S_BITS + X_BITS;

  // Octet that carries status bit b
  function automatic int src_octet(input int b);
    if (b >= X_BITS + S_BITS) return E_OCTET;
    case (b)
      0: return 2;
      1: return 7;
      2: return 1;
      3: return 3;
      4: return 4;
      5: return 6;
      6: return 8;
      default: return 9;
    endcase
  endfunction

  // Data bit inside that octet
  function automatic int src_bit(input int b);
    if (b >= X_BITS + S_BITS) return b - (X_BITS + S_BITS);
    return 0;
  endfunction
endpackage

// File: rtl/v110_octet_track.sv
module v110_octet_track #(
  parameter int FRAME_OCTETS = v110_pkg::FRAME_OCTETS,
  localparam int CW = $clog2(FRAME_OCTETS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oct_valid,
  input  logic          oct_sof,
  output logic          oct_take,
  output logic [CW-1:0] oct_idx,
  output logic          frm_end
);
  localparam logic [CW-1:0] IDLE = CW'(FRAME_OCTETS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_OCTETS - 1);

  logic [CW-1:0] pos_q;

  assign oct_take = oct_valid && (oct_sof || pos_q != IDLE);
  assign oct_idx  = oct_sof ? '0 : pos_q;
  assign frm_end  = oct_valid && !oct_sof && pos_q == LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= IDLE;
    end else if (oct_valid) begin
      if (oct_sof)            pos_q <= CW'(1);
      else if (pos_q != IDLE) pos_q <= pos_q + CW'(1);
    end
  end
endmodule

// File: rtl/v110_bit_pick.sv
module v110_bit_pick #(
  parameter int FRAME_OCTETS = v110_pkg::FRAME_OCTETS,
  localparam int CW = $clog2(FRAME_OCTETS + 1),
  localparam int SW = v110_pkg::STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oct_take,
  input  logic [CW-1:0] oct_idx,
  input  logic [7:0]    oct_data,
  output logic [SW-1:0] frm_now
);
  logic [SW-1:0] held_q;

  for (genvar b = 0; b < SW; b++) begin : g_bit
    localparam int OCT = v110_pkg::src_octet(b);
    localparam int POS = v110_pkg::src_bit(b);
    assign frm_now[b] = (oct_take && oct_idx == CW'(OCT)) ? oct_data[POS] : held_q[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= frm_now;
  end
endmodule

// File: rtl/v110_chg_report.sv
module v110_chg_report #(
  localparam int SW = v110_pkg::STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_end,
  input  logic [SW-1:0] frm_now,
  input  logic          abort_req,
  output logic          chg_valid,
  output logic [SW-1:0] chg_status,
  output logic [SW-1:0] ref_word
);
  logic abort_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_valid  <= 1'b0;
      chg_status <= '0;
      ref_word   <= '0;
      abort_pend <= 1'b0;
    end else begin
      chg_valid <= 1'b0;
      if (frm_end) begin
        abort_pend <= 1'b0;
        if (abort_pend || abort_req) begin
          chg_valid  <= 1'b1;
          chg_status <= '0;
          ref_word   <= '0;
        end else if (frm_now != ref_word) begin
          chg_valid  <= 1'b1;
          chg_status <= frm_now;
          ref_word   <= frm_now;
        end
      end else if (abort_req) begin
        abort_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/v110_chg_det.sv
module v110_chg_det #(
  parameter int FRAME_OCTETS = v110_pkg::FRAME_OCTETS,
  localparam int CW = $clog2(FRAME_OCTETS + 1),
  localparam int SW = v110_pkg::STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oct_valid,
  output logic          oct_ready,
  input  logic [7:0]    oct_data,
  input  logic          oct_sof,
  input  logic          abort_req,
  output logic          chg_valid,
  output logic [SW-1:0] chg_status
);
  logic          oct_take;
  logic [CW-1:0] oct_idx;
  logic          frm_end;
  logic [SW-1:0] frm_now;
  logic [SW-1:0] ref_word;

  assign oct_ready = 1'b1;

  v110_octet_track #(.FRAME_OCTETS(FRAME_OCTETS)) i_track (
    .clk(clk), .rst_n(rst_n), .oct_valid(oct_valid), .oct_sof(oct_sof),
    .oct_take(oct_take), .oct_idx(oct_idx), .frm_end(frm_end)
  );

  v110_bit_pick #(.FRAME_OCTETS(FRAME_OCTETS)) i_pick (
    .clk(clk), .rst_n(rst_n), .oct_take(oct_take), .oct_idx(oct_idx),
    .oct_data(oct_data), .frm_now(frm_now)
  );

  v110_chg_report i_report (
    .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .frm_now(frm_now),
    .abort_req(abort_req), .chg_valid(chg_valid), .chg_status(chg_status),
    .ref_word(ref_word)
  );
endmodule

// File: rtl/v110_chg_det_chk.sv
module v110_chg_det_chk #(
  localparam int SW = v110_pkg::STAT_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oct_ready,
  input logic          frm_end,
  input logic          abort_req,
  input logic          chg_valid,
  input logic [SW-1:0] chg_status,
  input logic [SW-1:0] ref_word
);
  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) oct_ready);

  // R4
  strobe_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> $past(frm_end));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |=> !chg_valid);

  // R7
  abort_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && abort_req) |=> (chg_valid && chg_status == '0));

  // R6
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_end |=> $stable(ref_word));

  // R6
  ref_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> ref_word == chg_status);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!chg_valid && ref_word == '0));
endmodule

bind v110_chg_det v110_chg_det_chk i_chk (
  .clk(clk), .rst_n(rst_n), .oct_ready(oct_ready), .frm_end(frm_end),
  .abort_req(abort_req), .chg_valid(chg_valid), .chg_status(chg_status),
  .ref_word(ref_word)
);

// File: tb/test_v110_chg_det.sv
module test_v110_chg_det;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        oct_valid = 1'b0;
  logic        oct_ready;
  logic [7:0]  oct_data = '0;
  logic        oct_sof = 1'b0;
  logic        abort_req = 1'b0;
  logic        chg_valid;
  logic [14:0] chg_status;

  int checks = 0;
  int errors = 0;
  logic [14:0] exp_q[$];
  string       tag_q[$];
  logic [14:0] tb_ref = '0;
  bit          tb_pend = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  v110_chg_det i_v110_chg_det (
    .clk(clk), .rst_n(rst_n), .oct_valid(oct_valid), .oct_ready(oct_ready),
    .oct_data(oct_data), .oct_sof(oct_sof), .abort_req(abort_req),
    .chg_valid(chg_valid), .chg_status(chg_status)
  );

  task automatic check(input bit ok, input string what, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Monitor: each report is popped and compared (R3, R4, R5, R7)
  always @(negedge clk) begin
    if (rst_n && chg_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected report", chg_status, 15'h0);
      end else begin
        automatic logic [14:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(chg_status == e, t, chg_status, e);
      end
    end
  end

  // Bit 0 of octet k per the R3 mapping
  function automatic logic tb_bit0(input int k, input logic [5:0] s, input logic [1:0] x);
    case (k)
      1: return s[0];
      3: return s[1];
      4: return s[2];
      6: return s[3];
      8: return s[4];
      9: return s[5];
      2: return x[0];
      7: return x[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic beat(input logic [7:0] d, input bit sof, input bit ab);
    @(negedge clk);
    oct_valid = 1'b1; oct_data = d; oct_sof = sof; abort_req = ab;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      oct_valid = 1'b0; oct_sof = 1'b0; abort_req = 1'b0;
      oct_data = 8'hA5;
    end
  endtask

  // Driver: computes the expected report and pushes it, then drives the frame
  task automatic send_frame(input logic [14:0] w, input int abort_at, input bit gaps,
                            input int fill, input string tag);
    if (abort_at >= 0 || tb_pend) begin
      exp_q.push_back(15'h0); tag_q.push_back({tag, " (R7 abort zero)"});
      tb_ref = '0; tb_pend = 0;
    end else if (w != tb_ref) begin
      exp_q.push_back(w); tag_q.push_back(tag);
      tb_ref = w;
    end
    for (int k = 0; k < 10; k++) begin
      logic [7:0] d;
      if (k == 0)      d = 8'h00;
      else if (k == 5) d = {1'b1, w[14:8]};
      else             d = {1'b1, 6'(k * 11 + fill), tb_bit0(k, w[7:2], w[1:0])};
      if (fill[0] && k != 0) d[7] = 1'b0;   // R9 leading bit ignored
      beat(d, k == 0, k == abort_at);
      if (gaps && k[0]) idle(1);
    end
    idle(3);
    check(exp_q.size() == 0, {tag, " R6 report count"}, 15'(exp_q.size()), 15'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state, R1 ready
    check(chg_valid == 1'b0, "R8 chg_valid in reset", 15'(chg_valid), 15'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(oct_ready == 1'b1, "R1 oct_ready high", 15'(oct_ready), 15'h1);
    // R2: octets before first start are ignored
    for (int i = 0; i < 12; i++) beat(8'hFF, 0, 0);
    idle(3);
    check(exp_q.size() == 0, "R2 pre-start octets ignored", 15'h0, 15'h0);
    // R8: all-zero first frame is silent
    send_frame(15'h0000, -1, 0, 3, "R8 zero first frame");
    send_frame({7'h55, 6'h00, 2'b00}, -1, 0, 4, "R4 E change");
    send_frame({7'h55, 6'h00, 2'b00}, -1, 0, 9, "R6 repeat silent");
    send_frame({7'h55, 6'h00, 2'b10}, -1, 1, 2, "R3 X bit from octet 7");
    send_frame({7'h2A, 6'h2D, 2'b01}, -1, 0, 5, "R5 merged E/S/X change");
    send_frame({7'h2A, 6'h2D, 2'b01}, -1, 1, 7, "R1 gaps repeat silent");
    // R9: filler bits differ only
    send_frame({7'h2A, 6'h2D, 2'b01}, -1, 0, 40, "R9 filler only silent");
    // R3: walking one across every status bit
    for (int b = 0; b < 15; b++)
      send_frame(15'(1) << b, -1, b[0], b, "R3 walking bit");
    // R7: abort in a changed frame
    send_frame({7'h7F, 6'h3F, 2'b11}, 4, 0, 1, "R7 abort mid frame");
    send_frame(15'h0000, -1, 0, 6, "R7 ref cleared silent");
    send_frame({7'h01, 6'h00, 2'b00}, -1, 0, 8, "R4 after abort");
    // R7: abort in an unchanged frame still reports
    send_frame({7'h01, 6'h00, 2'b00}, 9, 0, 10, "R7 abort on last octet");
    // R7: abort between frames
    send_frame({7'h03, 6'h11, 2'b10}, -1, 0, 12, "R4 before idle abort");
    @(negedge clk); abort_req = 1'b1;
    @(negedge clk); abort_req = 1'b0;
    tb_pend = 1;
    send_frame({7'h03, 6'h11, 2'b10}, -1, 0, 14, "R7 idle abort");
    send_frame({7'h03, 6'h11, 2'b10}, -1, 0, 16, "R4 after idle abort");
    // R7: the abort report is issued only once
    send_frame({7'h03, 6'h11, 2'b10}, -1, 0, 18, "R7 single abort report");
    // R2: truncated frame abandoned by a new start; stray octets after a frame
    beat(8'h00, 1, 0);
    for (int k = 1; k < 7; k++) beat(8'hFF, 0, 0);
    send_frame({7'h03, 6'h11, 2'b10}, -1, 0, 20, "R2 restart silent");
    for (int i = 0; i < 4; i++) beat(8'hFF, 0, 0);
    idle(3);
    check(exp_q.size() == 0, "R2 stray octets ignored", 15'h0, 15'h0);
    send_frame({7'h40, 6'h01, 2'b00}, -1, 0, 22, "R2 frame after strays");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule